// File: doc/BRIEF.md
# Floating-Point Operation Sequencer

This block is the control shell around a multi-cycle double-precision arithmetic unit. A host places two 64-bit operands, a 3-bit operation code and a 2-bit rounding mode on the inputs and raises a start strobe. The sequencer latches all of them and presents them, held steady, to the arithmetic datapaths. It then counts a fixed number of cycles chosen by the operation. When the count ends, it registers the datapath's 64-bit result and its five exception flags and raises `ready_o`.

The arithmetic itself sits outside this block, behind a plain result interface (`dp_result_i`, `dp_flags_i`). The sequencer only decides when those inputs are valid, routes the operation code to them and holds what it captured. Codes outside the four defined operations never reach the datapath. They complete on their own, with a zero result and the invalid flag set. The result and flags stay unchanged while ready is high. Ready drops when the next operation is accepted.

Top module: `fpop_sequencer`

## Requirements
- R1: While reset is sampled high at a clock edge, and after it, `ready_o`, `dp_go_o`, `result_o`, all five flags and the `dp_*` operand outputs are zero. Reset is synchronous and also aborts an operation in progress, so no completion follows.
- R2: An operation is accepted only at a clock edge where `start_i` is high, `start_i` was low at the previous edge and no operation is in progress. Holding `start_i` high for more cycles, or a new rising edge while an operation is in progress, has no effect.
- R3: At acceptance, `opa_i`, `opb_i`, `op_i` and `rmode_i` are latched onto `dp_opa_o`, `dp_opb_o`, `dp_op_o` and `dp_rmode_o`. They stay unchanged until the next accepted operation. For a defined code, `dp_go_o` is high for exactly the one cycle after the accepting edge.
- R4: `ready_o` rises exactly L clock edges after the accepting edge. L is 20 for code 000 (add), 21 for 001 (subtract), 24 for 010 (multiply) and 71 for 011 (divide).
- R5: `dp_op_o` carries the accepted 3-bit code unchanged, so the datapath sees 000 add, 001 subtract, 010 multiply and 011 divide.
- R6: A code with bit 2 set (1xx) never pulses `dp_go_o`. It completes after 20 edges with `result_o` zero, `invalid_o` high and the other four flags low, whatever the datapath presents.
- R7: At the edge where `ready_o` rises for a defined code, `result_o` takes `dp_result_i`. The flags take `dp_flags_i` with bit 4 invalid, 3 exception, 2 inexact, 1 overflow and 0 underflow.
- R8: Once high, `ready_o`, `result_o` and the flags stay unchanged until an operation is accepted. `ready_o` is low from the edge that accepts the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe; its rising edge starts an operation |
| op_i | input | 3 | Operation code |
| rmode_i | input | 2 | Rounding mode, passed through |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| dp_go_o | output | 1 | One-cycle launch pulse to the datapath |
| dp_op_o | output | 3 | Latched operation code to the datapath |
| dp_rmode_o | output | 2 | Latched rounding mode to the datapath |
| dp_opa_o | output | 64 | Latched first operand |
| dp_opb_o | output | 64 | Latched second operand |
| dp_result_i | input | 64 | Datapath result word |
| dp_flags_i | input | 5 | Datapath flags {invalid, exception, inexact, overflow, underflow} |
| result_o | output | 64 | Registered result |
| ready_o | output | 1 | Result and flags valid |
| underflow_o | output | 1 | Underflow flag |
| overflow_o | output | 1 | Overflow flag |
| inexact_o | output | 1 | Inexact flag |
| exception_o | output | 1 | Exception flag |
| invalid_o | output | 1 | Invalid flag |

## Verification
The hardest situation to reach is a second rising edge on the start strobe while an operation is still counting, together with operand inputs that change under the running operation. The stimulus creates it directly. After the normal two-cycle strobe it drops start, scrambles the operands, then pulses start again in the middle of the count. Only the measured latency and the held operands show whether that edge was wrongly taken. A reset issued mid-count and a strobe held far longer than two cycles cover the other two ways the timer could be restarted or cut short.

// File: rtl/fpseq_pkg.sv
package fpseq_pkg;

    localparam logic [2:0] OPC_ADD = 3'b000;
    localparam logic [2:0] OPC_SUB = 3'b001;
    localparam logic [2:0] OPC_MUL = 3'b010;
    localparam logic [2:0] OPC_DIV = 3'b011;

    typedef struct packed {
        logic invalid;
        logic exception;
        logic inexact;
        logic overflow;
        logic underflow;
    } fp_flags_t;

    function automatic logic opc_defined(input logic [2:0] opc);
        return opc[2] == 1'b0;
    endfunction

endpackage

// File: rtl/fpseq_strobe.sv
module fpseq_strobe (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic idle_i,
    output logic accept_o
);
    typedef struct packed {
        logic prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = start_i;
        accept_o  = start_i && !st_q.prev && idle_i;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> !accept_o); // R2

endmodule

// File: rtl/fpseq_timer.sv
module fpseq_timer #(
    parameter int unsigned LAT_ADD = 20,
    parameter int unsigned LAT_SUB = 21,
    parameter int unsigned LAT_MUL = 24,
    parameter int unsigned LAT_DIV = 71
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [2:0] opc_i,
    output logic       busy_o,
    output logic       done_o
);
    import fpseq_pkg::*;

    localparam int unsigned LAT_M1 = (LAT_ADD > LAT_SUB) ? LAT_ADD : LAT_SUB;
    localparam int unsigned LAT_M2 = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int unsigned LAT_MAX = (LAT_M1 > LAT_M2) ? LAT_M1 : LAT_M2;
    localparam int unsigned CNT_W = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] span_m1(input logic [2:0] opc);
        case (opc)
            OPC_SUB: return CNT_W'(LAT_SUB - 1);
            OPC_MUL: return CNT_W'(LAT_MUL - 1);
            OPC_DIV: return CNT_W'(LAT_DIV - 1);
            default: return CNT_W'(LAT_ADD - 1);
        endcase
    endfunction

    logic at_end;
    assign at_end = st_q.busy && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = span_m1(opc_i);
        end else if (st_q.busy) begin
            if (at_end) st_d.busy = 1'b0;
            else        st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign done_o = at_end;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.busy |-> (int'(st_q.cnt) < int'(LAT_MAX))); // R4
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o); // R4
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (busy_o && !done_o)); // R4

endmodule

// File: rtl/fpseq_result.sv
module fpseq_result #(
    parameter int unsigned DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept_i,
    input  logic                  done_i,
    input  logic                  bad_opc_i,
    input  logic [DATA_W-1:0]     dp_result_i,
    input  fpseq_pkg::fp_flags_t  dp_flags_i,
    output logic [DATA_W-1:0]     result_o,
    output fpseq_pkg::fp_flags_t  flags_o,
    output logic                  ready_o
);
    import fpseq_pkg::*;

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] res;
        fp_flags_t         flg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.ready = 1'b0;
        end else if (done_i) begin
            st_d.ready = 1'b1;
            if (bad_opc_i) begin
                st_d.res         = '0;
                st_d.flg         = '0;
                st_d.flg.invalid = 1'b1;
            end else begin
                st_d.res = dp_result_i;
                st_d.flg = dp_flags_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign flags_o  = st_q.flg;
    assign ready_o  = st_q.ready;

    AST_HOLD_WHILE_READY: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !accept_i) |=> (ready_o && $stable(result_o) && $stable(flags_o))); // R8
    AST_BAD_OPC_OUT: assert property (@(posedge clk) disable iff (rst)
        (done_i && bad_opc_i && !accept_i) |=> (flags_o == 5'b10000 && result_o == '0)); // R6
    AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> !ready_o); // R8

endmodule

// File: rtl/fpop_sequencer.sv
module fpop_sequencer #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned LAT_ADD = 20,
    parameter int unsigned LAT_SUB = 21,
    parameter int unsigned LAT_MUL = 24,
    parameter int unsigned LAT_DIV = 71
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        rmode_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic              dp_go_o,
    output logic [2:0]        dp_op_o,
    output logic [1:0]        dp_rmode_o,
    output logic [DATA_W-1:0] dp_opa_o,
    output logic [DATA_W-1:0] dp_opb_o,
    input  logic [DATA_W-1:0] dp_result_i,
    input  logic [4:0]        dp_flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ready_o,
    output logic              underflow_o,
    output logic              overflow_o,
    output logic              inexact_o,
    output logic              exception_o,
    output logic              invalid_o
);
    import fpseq_pkg::*;

    typedef struct packed {
        logic              go;
        logic [2:0]        opc;
        logic [1:0]        rm;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
    } lat_t;

    lat_t lat_d, lat_q;

    logic      accept;
    logic      busy;
    logic      done;
    fp_flags_t flags;

    fpseq_strobe u_strobe (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .idle_i   (!busy),
        .accept_o (accept)
    );

    fpseq_timer #(
        .LAT_ADD (LAT_ADD),
        .LAT_SUB (LAT_SUB),
        .LAT_MUL (LAT_MUL),
        .LAT_DIV (LAT_DIV)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .opc_i  (op_i),
        .busy_o (busy),
        .done_o (done)
    );

    always_comb begin
        lat_d    = lat_q;
        lat_d.go = 1'b0;
        if (accept) begin
            lat_d.go  = opc_defined(op_i);
            lat_d.opc = op_i;
            lat_d.rm  = rmode_i;
            lat_d.a   = opa_i;
            lat_d.b   = opb_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) lat_q <= '0;
        else     lat_q <= lat_d;
    end

    fpseq_result #(
        .DATA_W (DATA_W)
    ) u_result (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .done_i      (done),
        .bad_opc_i   (!opc_defined(lat_q.opc)),
        .dp_result_i (dp_result_i),
        .dp_flags_i  (fp_flags_t'(dp_flags_i)),
        .result_o    (result_o),
        .flags_o     (flags),
        .ready_o     (ready_o)
    );

    assign dp_go_o     = lat_q.go;
    assign dp_op_o     = lat_q.opc;
    assign dp_rmode_o  = lat_q.rm;
    assign dp_opa_o    = lat_q.a;
    assign dp_opb_o    = lat_q.b;
    assign underflow_o = flags.underflow;
    assign overflow_o  = flags.overflow;
    assign inexact_o   = flags.inexact;
    assign exception_o = flags.exception;
    assign invalid_o   = flags.invalid;

    AST_OPND_STABLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(dp_opa_o) && $stable(dp_opb_o) && $stable(dp_op_o) && $stable(dp_rmode_o))); // R3
    AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
        dp_go_o |=> !dp_go_o); // R3
    AST_GO_DEFINED: assert property (@(posedge clk) disable iff (rst)
        dp_go_o |-> (dp_op_o[2] == 1'b0)); // R6
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !busy); // R8

endmodule

// File: tb/fpop_sequencer_bench.sv
module fpop_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [1:0]  rm = 2'b00;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        dp_go;
    logic [2:0]  dp_op;
    logic [1:0]  dp_rm;
    logic [63:0] dp_a, dp_b, dp_res, result;
    logic [4:0]  dp_flg;
    logic        ready, uf, ovf, inx, exc, inv;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [63:0] stub_res(input logic [63:0] a, input logic [63:0] b,
                                             input logic [2:0] o, input logic [1:0] r);
        return a ^ {b[31:0], b[63:32]} ^ {59'b0, r, o};
    endfunction

    function automatic logic [4:0] stub_flg(input logic [63:0] a, input logic [1:0] r);
        return a[4:0] ^ {3'b0, r};
    endfunction

    // datapath stand-in
    assign dp_res = stub_res(dp_a, dp_b, dp_op, dp_rm);
    assign dp_flg = stub_flg(dp_a, dp_rm);

    fpop_sequencer u_fpop_sequencer (
        .clk (clk), .rst (rst), .start_i (start), .op_i (op), .rmode_i (rm),
        .opa_i (opa), .opb_i (opb),
        .dp_go_o (dp_go), .dp_op_o (dp_op), .dp_rmode_o (dp_rm),
        .dp_opa_o (dp_a), .dp_opb_o (dp_b),
        .dp_result_i (dp_res), .dp_flags_i (dp_flg),
        .result_o (result), .ready_o (ready),
        .underflow_o (uf), .overflow_o (ovf), .inexact_o (inx),
        .exception_o (exc), .invalid_o (inv)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit          m_valid = 1'b0;
    bit          m_prev, m_busy, m_ready, m_go;
    int          m_rem;
    logic [63:0] m_res, m_a, m_b;
    logic [4:0]  m_flg;
    logic [2:0]  m_op;
    logic [1:0]  m_rm;

    function automatic int span(input logic [2:0] o);
        case (o)
            3'b001:  return 21;
            3'b010:  return 24;
            3'b011:  return 71;
            default: return 20;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 1'b1;
            m_prev = 0; m_busy = 0; m_ready = 0; m_go = 0; m_rem = 0;
            m_res = '0; m_a = '0; m_b = '0; m_flg = '0; m_op = '0; m_rm = '0;
        end else begin
            m_go = 1'b0;
            if (start && !m_prev && !m_busy) begin
                m_a = opa; m_b = opb; m_op = op; m_rm = rm;
                m_busy = 1'b1; m_rem = span(op); m_ready = 1'b0;
                m_go = (op < 3'd4);
            end else if (m_busy) begin
                m_rem--;
                if (m_rem == 0) begin
                    m_busy = 1'b0;
                    m_ready = 1'b1;
                    if (m_op < 3'd4) begin
                        m_res = stub_res(m_a, m_b, m_op, m_rm);
                        m_flg = stub_flg(m_a, m_rm);
                    end else begin
                        m_res = '0;
                        m_flg = 5'b10000;
                    end
                end
            end
            m_prev = start;
        end
    end

    always @(negedge clk) begin
        if (m_valid && !finished) begin
            check(ready === m_ready, "R4 ready", 64'(ready), 64'(m_ready));
            check(result === m_res, "R7 result", result, m_res);
            check({inv, exc, inx, ovf, uf} === m_flg, "R7 flags", 64'({inv, exc, inx, ovf, uf}), 64'(m_flg));
            check(dp_go === m_go, "R3 go", 64'(dp_go), 64'(m_go));
            check(dp_a === m_a && dp_b === m_b && dp_rm === m_rm, "R3 operands", dp_a, m_a);
            check(dp_op === m_op, "R5 opcode", 64'(dp_op), 64'(m_op));
        end
    end

    bit saw_go;
    always @(negedge clk) if (dp_go === 1'b1) saw_go = 1'b1;

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] r, input int hold, input bit poke, output int lat);
        int n = 0;
        @(negedge clk);
        opa = a; opb = b; op = o; rm = r; start = 1'b1;
        saw_go = 1'b0;
        lat = -1;
        while (n < 300) begin
            @(negedge clk);
            n++;
            if (n == hold) start = 1'b0;
            if (n == hold + 1) begin opa = ~a; opb = a; op = ~o; rm = ~r; end
            if (poke && n == hold + 4) start = 1'b1;
            if (poke && n == hold + 5) start = 1'b0;
            if (n == 1) check(ready === 1'b0, "R8 ready cleared by start", 64'(ready), 64'd0);
            if (ready === 1'b1) begin
                lat = n - 1;
                break;
            end
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lat;
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ready === 1'b0 && dp_go === 1'b0, "R1 ready/go at reset", 64'({ready, dp_go}), 64'd0);
        check(result === '0 && {inv, exc, inx, ovf, uf} === 5'b0, "R1 result/flags at reset", result, 64'd0);
        check(dp_a === '0 && dp_b === '0, "R1 operands at reset", dp_a, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        run_op(3'b000, 64'h3ff0_0000_0000_0001, 64'h4000_0000_0000_0000, 2'b00, 2, 1'b0, lat);
        check(lat == 20, "R4 add latency", 64'(lat), 64'd20);
        run_op(3'b001, 64'hc010_1234_5678_9abc, 64'h0000_0000_0000_0007, 2'b01, 2, 1'b0, lat);
        check(lat == 21, "R4 sub latency", 64'(lat), 64'd21);
        run_op(3'b010, 64'h7fef_ffff_ffff_ffff, 64'h0010_0000_0000_0000, 2'b10, 2, 1'b0, lat);
        check(lat == 24, "R4 mul latency", 64'(lat), 64'd24);
        check(dp_a === 64'h7fef_ffff_ffff_ffff, "R3 operand held after scramble", dp_a, 64'h7fef_ffff_ffff_ffff);
        check(dp_op === 3'b010, "R5 multiply code routed", 64'(dp_op), 64'd2);
        run_op(3'b011, 64'h8000_0000_0000_001f, 64'h3fe0_0000_0000_0000, 2'b11, 2, 1'b0, lat);
        check(lat == 71, "R4 div latency", 64'(lat), 64'd71);
        check({inv, exc, inx, ovf, uf} === 5'b11100, "R7 flags from datapath", 64'({inv, exc, inx, ovf, uf}), 64'h1c);

        // R2: second rising edge mid-operation ignored; long hold ignored
        run_op(3'b000, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 2'b01, 2, 1'b1, lat);
        check(lat == 20, "R2 mid-operation start ignored", 64'(lat), 64'd20);
        run_op(3'b010, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005, 2'b00, 9, 1'b0, lat);
        check(lat == 24, "R2 long strobe hold", 64'(lat), 64'd24);

        // R8: output held while ready, inputs moving
        held = result;
        repeat (12) begin
            @(negedge clk);
            opa = opa + 64'd3; opb = ~opb; op = op + 3'd1;
        end
        check(ready === 1'b1 && result === held, "R8 output held while ready", result, held);

        // R6: unused codes
        run_op(3'b101, 64'hffff_ffff_ffff_ffff, 64'h1, 2'b10, 2, 1'b0, lat);
        check(lat == 20, "R6 unused code latency", 64'(lat), 64'd20);
        check(result === '0 && {inv, exc, inx, ovf, uf} === 5'b10000, "R6 unused code result",
              64'({inv, exc, inx, ovf, uf}), 64'h10);
        check(saw_go === 1'b0, "R6 no launch for unused code", 64'(saw_go), 64'd0);
        run_op(3'b111, 64'h5555_5555_5555_5555, 64'haaaa, 2'b11, 2, 1'b0, lat);
        check(lat == 20 && inv === 1'b1, "R6 code 111 invalid", 64'(lat), 64'd20);

        // R1: reset aborts a running operation
        @(negedge clk);
        opa = 64'h42; opb = 64'h24; op = 3'b011; rm = 2'b00; start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(ready === 1'b0 && result === '0, "R1 reset mid-operation", result, 64'd0);
        repeat (90) @(negedge clk);
        check(ready === 1'b0, "R1 no completion after abort", 64'(ready), 64'd0);

        run_op(3'b001, 64'h1111_2222_3333_4444, 64'h5, 2'b10, 2, 1'b0, lat);
        check(lat == 21, "R4 sub after abort", 64'(lat), 64'd21);
        check(result === stub_res(64'h1111_2222_3333_4444, 64'h5, 3'b001, 2'b10), "R7 result after abort",
              result, stub_res(64'h1111_2222_3333_4444, 64'h5, 3'b001, 2'b10));
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule